// File: doc/BRIEF.md
# Timer-Compare Interrupt and Status Unit

This block holds the timer and interrupt-gating state of a processor's system-control coprocessor. A free-running 32-bit counter advances on each enabled tick. A 32-bit compare value is checked against it. When the two are equal, a sticky timer-pending flag is raised, and only a new write to the compare register clears it. A status word carries the global interrupt enable, the two exception-level blocking bits, an eight-bit interrupt mask and several plain storage fields. A cause word reports the pending sources: the timer, the hardware lines and two software-settable bits.

Software reaches all four registers through one port. The port has a 5-bit register number, a write strobe, write data and combinational read data. The numbers are: counter 9, compare 11, status 12, cause 13. Five hardware interrupt lines come in, but only the lower three are live. The block drives a single interrupt request. That request is high when interrupts are globally enabled, neither exception-level bit is set, and some pending source is unmasked.

Top module: `tcmp_irq_unit`

## Requirements
- R1: With `tick_en` high and no counter write, the counter (register 9) increases by one per clock and wraps from 0xFFFFFFFF to 0. With `tick_en` low it holds its value.
- R2: A write to register 9 loads the write data into the counter on that clock, taking precedence over a tick in the same cycle.
- R3: The compare register (11) stores all 32 written bits and reads them back unchanged.
- R4: When counter equals compare, cause bit 15 (timer pending) reads 1 from the next cycle on. It stays 1 until a compare write, even after the counter moves past the match.
- R5: Any write to register 11, whatever its value, makes cause bit 15 read 0 in the following cycle. This holds even when counter equals compare in the cycle of the write.
- R6: Status (12) bits 7:0, 15:8 (mask), 24:16 and 28 are writable. Bit 25 (reverse-endian) and bits 31:29, 27:26 always read 0. Bit 0 is the global enable, bit 1 and bit 2 are the exception-level blocks, and mask bit 8+k gates cause bit 8+k.
- R7: During and directly after reset, counter reads 0, status reads 0x00000004 (bit 2 set), cause reads 0 with all inputs low, and `irq_req` is 0.
- R8: Cause bits 12:10 show `hw_int[2:0]` in the same cycle without latching. Cause bits 14:13 always read 0, and `hw_int[4:3]` cannot raise `irq_req`.
- R9: Cause bits 9:8 are written by a cause write. All other cause bits ignore writes, and cause bits other than 15:8 read 0.
- R10: `irq_req` is 1 exactly when status bit 0 is 1, status bits 1 and 2 are 0, and cause[15:8] AND status[15:8] is non-zero.
- R11: Register numbers other than 9, 11, 12 and 13 read as 0, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_en | input | 1 | Counter advance enable for this cycle |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 5 | Register number for read and write |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Combinational read data of the selected register |
| hw_int | input | 5 | Hardware interrupt lines (only bits 2:0 live) |
| irq_req | output | 1 | Interrupt request |

## Verification
A wrong timer-pending flag shows up in cause bit 15 one clock after the counter and compare registers meet. If bit 15 does not set, fails to stay set, or survives a compare write, the fault is visible at the very next read. A gating error shows on `irq_req` in the same cycle as the status or pending change that causes it. The hardware lines are combinational, so a wrongly latched or mis-routed line is seen within one read of the cause register. The bench also forces a match and a compare write into the same cycle, so a reversed priority shows up at the next edge.

// File: rtl/tcmp_pkg.sv
// Package: register numbers and status-word layout shared by the
// timer-compare interrupt unit. Assumes a 32-bit status and cause word.
package tcmp_pkg;
    localparam int unsigned WORD_W = 32;
    localparam int unsigned RNUM_W = 5;

    localparam logic [RNUM_W-1:0] RN_COUNT   = 5'd9;
    localparam logic [RNUM_W-1:0] RN_COMPARE = 5'd11;
    localparam logic [RNUM_W-1:0] RN_STATUS  = 5'd12;
    localparam logic [RNUM_W-1:0] RN_CAUSE   = 5'd13;

    // status field positions
    localparam int unsigned ST_IE   = 0;
    localparam int unsigned ST_EXL  = 1;
    localparam int unsigned ST_ERL  = 2;
    localparam int unsigned ST_MSK  = 8;
    localparam int unsigned ST_RE   = 25;
    localparam int unsigned SRC_N   = 8;

    // writable status bits: 28, 24:16, 15:0 ; bit 25 held at zero
    localparam logic [WORD_W-1:0] ST_WMASK = 32'h11FF_FFFF;
    localparam logic [WORD_W-1:0] ST_RESET = 32'h0000_0004;

    // position of the pending byte inside the cause word
    localparam int unsigned CA_PEND = 8;
endpackage

// File: rtl/tcmp_counter.sv
// Module: tcmp_counter
// Holds the free-running counter, the compare value and the sticky
// timer-pending flag. Assumes writes arrive already decoded. The compare
// value has no reset state; software must load it before relying on it.
module tcmp_counter #(
    parameter int unsigned DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_en,
    input  logic              cnt_wr,
    input  logic              cmp_wr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] cnt_q,
    output logic [DATA_W-1:0] cmp_q,
    output logic              timer_pend
);
    localparam logic [DATA_W-1:0] ONE = DATA_W'(1);

    logic hit;

    // Counter: load on write, otherwise advance on an enabled tick
    always_ff @(posedge clk) begin
        if (!rst_n)       cnt_q <= '0;
        else if (cnt_wr)  cnt_q <= wdata;
        else if (tick_en) cnt_q <= cnt_q + ONE;
    end

    // Compare value: plain storage, deliberately not reset
    always_ff @(posedge clk) begin
        if (cmp_wr) cmp_q <= wdata;
    end

    // Equality between the two stored values
    always_comb hit = (cnt_q == cmp_q);

    // Pending flag: a compare write clears it and beats a match; a match sets it
    always_ff @(posedge clk) begin
        if (!rst_n)      timer_pend <= 1'b0;
        else if (cmp_wr) timer_pend <= 1'b0;
        else if (hit)    timer_pend <= 1'b1;
    end

    // R1
    count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_en && !cnt_wr) |=> (cnt_q == $past(cnt_q) + ONE));
    // R2
    count_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_wr |=> (cnt_q == $past(wdata)));
    // R4
    timer_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q == cmp_q && !cmp_wr) |=> timer_pend);
    // R4
    timer_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (timer_pend && !cmp_wr) |=> timer_pend);
    // R5
    timer_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmp_wr |=> !timer_pend);
endmodule

// File: rtl/tcmp_status.sv
// Module: tcmp_status
// Status word storage. Only the bits set in the write mask can take a
// written value; the rest, including the endian-reverse bit, stay zero.
module tcmp_status
    import tcmp_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              st_wr,
    input  logic [WORD_W-1:0] wdata,
    output logic [WORD_W-1:0] status_q
);
    logic [WORD_W-1:0] status_d;

    // Filter written data through the writable-bit mask
    always_comb status_d = wdata & ST_WMASK;

    // Status register with its reset value
    always_ff @(posedge clk) begin
        if (!rst_n)     status_q <= ST_RESET;
        else if (st_wr) status_q <= status_d;
    end

    // R6
    re_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !status_q[ST_RE]);
    // R6
    st_low_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_wr |=> (status_q[15:0] == $past(wdata[15:0])));
endmodule

// File: rtl/tcmp_cause_gate.sv
// Module: tcmp_cause_gate
// Builds the pending byte from the timer flag, the live hardware lines
// and the software bits, then gates it with mask and enable bits into
// the interrupt request. Hardware lines are not latched.
module tcmp_cause_gate
    import tcmp_pkg::*;
#(
    parameter int unsigned HW_W    = 5,
    parameter int unsigned HW_LIVE = 3,
    parameter int unsigned SW_W    = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cause_wr,
    input  logic [SW_W-1:0]   sw_wdata,
    input  logic [HW_W-1:0]   hw_int,
    input  logic              timer_pend,
    input  logic              g_en,
    input  logic              exl,
    input  logic              erl,
    input  logic [SRC_N-1:0]  src_mask,
    output logic [WORD_W-1:0] cause_q,
    output logic              irq_req
);
    localparam logic [HW_W-1:0] LIVE_MASK = HW_W'((1 << HW_LIVE) - 1);

    logic [SW_W-1:0]  sw_q;
    logic [HW_W-1:0]  hw_eff;
    logic [SRC_N-1:0] pend;

    // Software pending bits, written only through the cause register
    always_ff @(posedge clk) begin
        if (!rst_n)        sw_q <= '0;
        else if (cause_wr) sw_q <= sw_wdata;
    end

    // Dead hardware lines are forced low
    always_comb hw_eff = hw_int & LIVE_MASK;

    // Pending byte: timer on top, hardware in the middle, software at the bottom
    always_comb pend = {timer_pend, hw_eff, sw_q};

    // Cause word with the pending byte placed at its field
    always_comb begin
        cause_q = '0;
        cause_q[CA_PEND +: SRC_N] = pend;
    end

    // Request: enabled, not at an exception level, some unmasked source
    always_comb irq_req = g_en && !exl && !erl && (|(pend & src_mask));

    // R10
    irq_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!g_en || exl || erl) |-> !irq_req);
    // R8
    dead_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cause_q[14:13] == 2'b00);
    // R9
    sw_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cause_wr |=> (cause_q[9:8] == $past(sw_wdata)));
endmodule

// File: rtl/tcmp_irq_unit.sv
// Module: tcmp_irq_unit (top)
// Register-number decode, read mux and interconnect of the counter,
// status and cause/gating pieces. Reads are combinational; writes take
// effect at the clock edge on which reg_wr is high.
module tcmp_irq_unit
    import tcmp_pkg::*;
#(
    parameter int unsigned HW_W    = 5,
    parameter int unsigned HW_LIVE = 3,
    parameter int unsigned SW_W    = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_en,
    input  logic              reg_wr,
    input  logic [RNUM_W-1:0] reg_addr,
    input  logic [WORD_W-1:0] reg_wdata,
    output logic [WORD_W-1:0] reg_rdata,
    input  logic [HW_W-1:0]   hw_int,
    output logic              irq_req
);
    logic              wr_cnt, wr_cmp, wr_st, wr_cause;
    logic [WORD_W-1:0] cnt_q, cmp_q, status_q, cause_q;
    logic              timer_pend;

    // Write decode by register number
    always_comb begin
        wr_cnt   = reg_wr && (reg_addr == RN_COUNT);
        wr_cmp   = reg_wr && (reg_addr == RN_COMPARE);
        wr_st    = reg_wr && (reg_addr == RN_STATUS);
        wr_cause = reg_wr && (reg_addr == RN_CAUSE);
    end

    tcmp_counter #(.DATA_W(WORD_W)) u_cnt (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick_en    (tick_en),
        .cnt_wr     (wr_cnt),
        .cmp_wr     (wr_cmp),
        .wdata      (reg_wdata),
        .cnt_q      (cnt_q),
        .cmp_q      (cmp_q),
        .timer_pend (timer_pend)
    );

    tcmp_status u_st (
        .clk      (clk),
        .rst_n    (rst_n),
        .st_wr    (wr_st),
        .wdata    (reg_wdata),
        .status_q (status_q)
    );

    tcmp_cause_gate #(.HW_W(HW_W), .HW_LIVE(HW_LIVE), .SW_W(SW_W)) u_gate (
        .clk        (clk),
        .rst_n      (rst_n),
        .cause_wr   (wr_cause),
        .sw_wdata   (reg_wdata[CA_PEND +: SW_W]),
        .hw_int     (hw_int),
        .timer_pend (timer_pend),
        .g_en       (status_q[ST_IE]),
        .exl        (status_q[ST_EXL]),
        .erl        (status_q[ST_ERL]),
        .src_mask   (status_q[ST_MSK +: SRC_N]),
        .cause_q    (cause_q),
        .irq_req    (irq_req)
    );

    // Read mux; unmapped numbers return zero
    always_comb begin
        unique case (reg_addr)
            RN_COUNT:   reg_rdata = cnt_q;
            RN_COMPARE: reg_rdata = cmp_q;
            RN_STATUS:  reg_rdata = status_q;
            RN_CAUSE:   reg_rdata = cause_q;
            default:    reg_rdata = '0;
        endcase
    end

    // R7
    reset_quiet_chk: assert property (@(posedge clk)
        !rst_n |=> (!irq_req && cnt_q == '0));
endmodule

// File: tb/tcmp_irq_unit_tb.sv
// Directed bench for tcmp_irq_unit: one task per scenario.
module tcmp_irq_unit_tb;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_en = 1'b0;
    logic        reg_wr = 1'b0;
    logic [4:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [4:0]  hw_int = '0;
    logic        irq_req;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    tcmp_irq_unit u_dut (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .reg_wr(reg_wr),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .hw_int(hw_int), .irq_req(irq_req)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd_chk(input string req, input logic [4:0] a, input logic [31:0] exp);
        reg_addr = a;
        #1;
        chk(req, reg_rdata, exp);
    endtask

    task automatic irq_chk(input string req, input logic exp);
        #1;
        chk(req, {31'd0, irq_req}, {31'd0, exp});
    endtask

    task automatic ticks(input int n);
        @(negedge clk);
        tick_en = 1'b1;
        repeat (n) @(negedge clk);
        tick_en = 1'b0;
    endtask

    task automatic t_reset;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rd_chk("R7 count", 5'd9, 32'h0);
        rd_chk("R7 status", 5'd12, 32'h0000_0004);
        rd_chk("R7 cause", 5'd13, 32'h0);
        irq_chk("R7 irq", 1'b0);
        rst_n = 1'b1;
    endtask

    task automatic t_count;
        wr(5'd9, 32'hFFFF_FFFE);
        repeat (3) @(negedge clk);
        rd_chk("R1 hold", 5'd9, 32'hFFFF_FFFE);
        ticks(3);
        rd_chk("R1 wrap", 5'd9, 32'h0000_0001);
        @(negedge clk);
        tick_en = 1'b1;
        wr(5'd9, 32'h0000_0100);
        tick_en = 1'b0;
        rd_chk("R2 load beats tick", 5'd9, 32'h0000_0100);
    endtask

    task automatic t_compare_rw;
        wr(5'd11, 32'hA5A5_1234);
        rd_chk("R3 readback", 5'd11, 32'hA5A5_1234);
        rd_chk("R5 cleared", 5'd13, 32'h0);
    endtask

    task automatic t_match;
        wr(5'd11, 32'h0000_0050);
        wr(5'd9, 32'h0000_004D);
        rd_chk("R4 no match yet", 5'd13, 32'h0);
        ticks(5);
        rd_chk("R1 count", 5'd9, 32'h0000_0052);
        rd_chk("R4 set", 5'd13, 32'h0000_8000);
        ticks(3);
        rd_chk("R4 sticky", 5'd13, 32'h0000_8000);
    endtask

    task automatic t_clear;
        wr(5'd11, 32'h0000_1234);
        rd_chk("R5 any value", 5'd13, 32'h0);
        wr(5'd11, 32'h0000_0077);
        wr(5'd9, 32'h0000_0077);
        @(negedge clk);
        rd_chk("R4 equal", 5'd13, 32'h0000_8000);
        wr(5'd11, 32'h0000_0077);
        rd_chk("R5 write wins", 5'd13, 32'h0);
        @(negedge clk);
        rd_chk("R4 rematch", 5'd13, 32'h0000_8000);
        wr(5'd11, 32'hDEAD_0000);
        wr(5'd9, 32'h0);
    endtask

    task automatic t_status;
        wr(5'd12, 32'hFFFF_FFFF);
        rd_chk("R6 writable mask", 5'd12, 32'h11FF_FFFF);
        wr(5'd12, 32'h0);
        rd_chk("R6 clear", 5'd12, 32'h0);
    endtask

    task automatic t_cause;
        @(negedge clk);
        hw_int = 5'b11111;
        rd_chk("R8 live lines", 5'd13, 32'h0000_1C00);
        wr(5'd13, 32'hFFFF_FFFF);
        rd_chk("R9 sw set", 5'd13, 32'h0000_1F00);
        wr(5'd13, 32'h0);
        rd_chk("R9 sw clear", 5'd13, 32'h0000_1C00);
        hw_int = 5'b00000;
        rd_chk("R8 follows", 5'd13, 32'h0);
    endtask

    task automatic t_irq;
        wr(5'd12, 32'h0000_0101);
        wr(5'd13, 32'h0000_0100);
        irq_chk("R10 sw0 enabled", 1'b1);
        wr(5'd12, 32'h0000_0103);
        irq_chk("R10 exl blocks", 1'b0);
        wr(5'd12, 32'h0000_0105);
        irq_chk("R10 erl blocks", 1'b0);
        wr(5'd12, 32'h0000_0100);
        irq_chk("R10 ie off", 1'b0);
        wr(5'd12, 32'h0000_0201);
        irq_chk("R10 masked", 1'b0);
        wr(5'd13, 32'h0000_0200);
        irq_chk("R10 sw1", 1'b1);
        wr(5'd13, 32'h0);
        wr(5'd12, 32'h0000_6001);
        hw_int = 5'b11000;
        irq_chk("R8 dead lines", 1'b0);
        wr(5'd12, 32'h0000_0401);
        hw_int = 5'b00001;
        irq_chk("R10 hw line 0", 1'b1);
        hw_int = 5'b00000;
        irq_chk("R10 hw drop", 1'b0);
        wr(5'd12, 32'h0000_8001);
        wr(5'd11, 32'h0000_0020);
        wr(5'd9, 32'h0000_0020);
        @(negedge clk);
        irq_chk("R4 timer irq", 1'b1);
        wr(5'd11, 32'h0000_9999);
        irq_chk("R5 timer irq cleared", 1'b0);
    endtask

    task automatic t_unmapped;
        wr(5'd12, 32'h0000_0001);
        wr(5'd5, 32'hFFFF_FFFF);
        wr(5'd10, 32'hFFFF_FFFF);
        rd_chk("R11 read zero", 5'd5, 32'h0);
        rd_chk("R11 read zero 10", 5'd10, 32'h0);
        rd_chk("R11 count kept", 5'd9, 32'h0000_0020);
        rd_chk("R11 compare kept", 5'd11, 32'h0000_9999);
        rd_chk("R11 status kept", 5'd12, 32'h0000_0001);
        rd_chk("R11 cause kept", 5'd13, 32'h0);
    endtask

    initial begin
        t_reset();
        t_count();
        t_compare_rw();
        t_match();
        t_clear();
        t_status();
        t_cause();
        t_irq();
        t_unmapped();
        done = 1'b1;
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end
endmodule